// File: doc/BRIEF.md
# Top-of-Memory Firmware Range Decoder

This block sits on the processor's memory request path and decides where each access goes. Requests that land in the firmware region just under the 4 GB boundary go to the flash interface. Everything else goes to system memory. The flash image is placed so that its final byte is at FFFF_FFFFh. This puts the processor's start-up fetch address, FFFF_FFF0h, inside flash. The flash-relative offset for a request is its address minus (4 GB minus the image size).

A 16-bit enable word controls the firmware region. Bit n claims the 512 KB window that starts at FF80_0000h + n × 80000h. The top bit covers FFF8_0000h–FFFF_FFFFh. It cannot be cleared, and it reads back as 1. Bit 14 covers FFF0_0000h–FFF7_FFFFh. When an enable bit is clear, its window falls through to system memory. A legacy alias, selected by a parameter, also sends the 64 KB range 000F_0000h–000F_FFFFh to the last 64 KB of the image. Every flash-decoded range is read-only. A write to one of these ranges is dropped and flagged.

The request side is a valid/ready channel. `req_ready` is tied high, so the decoder accepts one request in every cycle and never applies back-pressure. The routed result appears one cycle later as single-cycle strobes. Downstream cannot stall these strobes.

Top module: `fwdec_top`

## Requirements
- R1: After reset, `cfg_rdata` reads FFCCh, and `flash_sel`, `mem_sel` and `wr_blocked` are low.
- R2: Bit 15 of the enable word always reads 1, whatever value is written.
- R3: A read accepted in FFF8_0000h–FFFF_FFFFh raises `flash_sel` in the next cycle, whatever the enable word holds. `flash_off` then equals the address minus FF80_0000h (the low 23 bits), so FFFF_FFF0h gives 7FFFF0h.
- R4: With bit 14 set, a read in FFF0_0000h–FFF7_FFFFh goes to flash. With bit 14 clear, the same read goes to system memory.
- R5: For every bit n that is set, reads in the window FF80_0000h + n × 80000h (size 80000h) go to flash. For every bit that is clear, those reads go to memory.
- R6: An access outside every enabled window and outside the alias raises `mem_sel` in the next cycle. `mem_addr` carries the request address and `mem_write` carries the request's write flag.
- R7: A write to any flash-decoded range (enabled window or alias) raises `wr_blocked` for one cycle, with both `flash_sel` and `mem_sel` low.
- R8: When the legacy alias is enabled, a read in 000F_0000h–000F_FFFFh goes to flash at offset 7F_0000h + address[15:0].
- R9: Each accepted request produces exactly one of `flash_sel`, `mem_sel` or `wr_blocked` in the following cycle. A cycle with no request produces none of them.
- R10: An enable-word write takes effect on the request accepted in the cycle after the write. A request in the same cycle as the write is decoded with the old value.
- R11: `req_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; decoder never stalls |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| cfg_we | input | 1 | Enable-word write strobe |
| cfg_wdata | input | 16 | Enable-word write value |
| cfg_rdata | output | 16 | Current enable word |
| flash_sel | output | 1 | Read routed to flash (one-cycle pulse) |
| flash_off | output | 23 | Flash-relative byte offset |
| mem_sel | output | 1 | Access routed to system memory (one-cycle pulse) |
| mem_write | output | 1 | Write flag of the memory access |
| mem_addr | output | 32 | Address of the memory access |
| wr_blocked | output | 1 | Write to read-only flash range dropped (one-cycle pulse) |

## Verification
The hardest case to reach is an enable-word write that lands in the same cycle as a request to the window it changes. The bench drives both on one falling edge and checks that the old routing applies. It then repeats the request one cycle later and checks the new routing. A second hard case is an attempt to clear the locked top bit. The bench writes all zeros and then confirms, through `cfg_rdata` and through a read of the start-up address, that the top window still decodes. The alias and the top window share flash offsets, so the bench compares the two offsets directly.

// File: rtl/fwdec_pkg.sv
package fwdec_pkg;
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_MEM   = 2'd1,
    RT_FLASH = 2'd2,
    RT_BLOCK = 2'd3
  } route_e;
endpackage

// File: rtl/fwdec_cfg.sv
module fwdec_cfg #(
  parameter int          NUM_WIN   = 16,
  parameter logic [15:0] RESET_VAL = 16'hFFCC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NUM_WIN-1:0] wdata,
  output logic [NUM_WIN-1:0] value
);
  // top window is hard-wired on
  localparam logic [NUM_WIN-1:0] LOCK = {1'b1, {(NUM_WIN-1){1'b0}}};

  logic [NUM_WIN-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= RESET_VAL[NUM_WIN-1:0] | LOCK;
    else if (we) en_q <= wdata | LOCK;
  end

  assign value = en_q;

  // R10: a write is visible in the following cycle, with the lock applied
  assert_cfg_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (value == ($past(wdata) | LOCK)));
endmodule

// File: rtl/fwdec_match.sv
module fwdec_match #(
  parameter int WIN_LOG2     = 19,
  parameter int NUM_WIN      = 16,
  parameter int IMG_LOG2     = 23,
  parameter bit LEGACY_ALIAS = 1'b1
) (
  input  logic [31:0]         addr,
  input  logic [NUM_WIN-1:0]  en,
  output logic                hit,
  output logic                alias_hit,
  output logic [IMG_LOG2-1:0] off
);
  localparam int TAG_W     = 32 - WIN_LOG2;
  localparam int TOP_TAG   = (1 << TAG_W) - NUM_WIN;
  localparam int IMG_WINS  = 1 << (IMG_LOG2 - WIN_LOG2);
  localparam int FIRST_WIN = (IMG_WINS >= NUM_WIN) ? 0 : NUM_WIN - IMG_WINS;

  logic [NUM_WIN-1:0] win_hit;

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    if (n >= FIRST_WIN) begin : g_in_image
      assign win_hit[n] = en[n] && (addr[31:WIN_LOG2] == TAG_W'(TOP_TAG + n));
    end else begin : g_outside
      assign win_hit[n] = 1'b0;
    end
  end

  if (LEGACY_ALIAS) begin : g_alias
    assign alias_hit = (addr[31:16] == 16'h000F);
  end else begin : g_no_alias
    assign alias_hit = 1'b0;
  end

  assign hit = (|win_hit) || alias_hit;
  assign off = alias_hit ? {{(IMG_LOG2-16){1'b1}}, addr[15:0]} : addr[IMG_LOG2-1:0];

  // R5: windows are disjoint, so at most one claims an address
  always_comb begin
    assert_one_window_R5: assert ($onehot0(win_hit));
  end
endmodule

// File: rtl/fwdec_top.sv
module fwdec_top
  import fwdec_pkg::*;
#(
  parameter int WIN_LOG2     = 19,
  parameter int NUM_WIN      = 16,
  parameter int IMG_LOG2     = 23,
  parameter bit LEGACY_ALIAS = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [31:0]         req_addr,
  input  logic                cfg_we,
  input  logic [NUM_WIN-1:0]  cfg_wdata,
  output logic [NUM_WIN-1:0]  cfg_rdata,
  output logic                flash_sel,
  output logic [IMG_LOG2-1:0] flash_off,
  output logic                mem_sel,
  output logic                mem_write,
  output logic [31:0]         mem_addr,
  output logic                wr_blocked
);
  localparam int TOP_TAG = (1 << (32 - WIN_LOG2)) - 1;

  logic [NUM_WIN-1:0]  en;
  logic                hit;
  logic                alias_hit;
  logic [IMG_LOG2-1:0] off;
  route_e              route_d, route_q;
  logic [IMG_LOG2-1:0] off_q;
  logic [31:0]         addr_q;
  logic                wr_q;

  fwdec_cfg #(.NUM_WIN(NUM_WIN)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .value (en)
  );

  fwdec_match #(
    .WIN_LOG2     (WIN_LOG2),
    .NUM_WIN      (NUM_WIN),
    .IMG_LOG2     (IMG_LOG2),
    .LEGACY_ALIAS (LEGACY_ALIAS)
  ) u_match (
    .addr      (req_addr),
    .en        (en),
    .hit       (hit),
    .alias_hit (alias_hit),
    .off       (off)
  );

  always_comb begin
    if (!req_valid)     route_d = RT_NONE;
    else if (!hit)      route_d = RT_MEM;
    else if (req_write) route_d = RT_BLOCK;
    else                route_d = RT_FLASH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= RT_NONE;
      off_q   <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      route_q <= route_d;
      if (req_valid) begin
        off_q  <= off;
        addr_q <= req_addr;
        wr_q   <= req_write;
      end
    end
  end

  assign req_ready  = 1'b1;
  assign cfg_rdata  = en;
  assign flash_sel  = (route_q == RT_FLASH);
  assign mem_sel    = (route_q == RT_MEM);
  assign wr_blocked = (route_q == RT_BLOCK);
  assign flash_off  = off_q;
  assign mem_addr   = addr_q;
  assign mem_write  = wr_q;

  // R9: exactly one outcome per accepted request
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ($countones({flash_sel, mem_sel, wr_blocked}) == 1));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(flash_sel || mem_sel || wr_blocked));
  // R3: the locked top window always reaches flash at the image offset
  assert_top_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[31:WIN_LOG2] == (32-WIN_LOG2)'(TOP_TAG))
    |=> (flash_sel && flash_off == $past(req_addr[IMG_LOG2-1:0])));
  // R7: writes that the matcher claims are blocked
  assert_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && hit) |=> (wr_blocked && !flash_sel && !mem_sel));
  // R8: alias reads land in the last 64 KB of the image
  assert_alias_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && alias_hit)
    |=> (flash_sel && flash_off[IMG_LOG2-1:16] == '1));
endmodule

// File: tb/tb_fwdec_top.sv
module tb_fwdec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        flash_sel;
  logic [22:0] flash_off;
  logic        mem_sel;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic        wr_blocked;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  fwdec_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .flash_sel(flash_sel),
    .flash_off(flash_off), .mem_sel(mem_sel), .mem_write(mem_write),
    .mem_addr(mem_addr), .wr_blocked(wr_blocked)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // route code: 1 flash, 2 mem, 4 blocked, 0 none
  function automatic logic [2:0] outs();
    return {wr_blocked, mem_sel, flash_sel};
  endfunction

  task automatic access(input bit wr, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_flash(input string tag, input logic [31:0] a,
                              input logic [22:0] off);
    access(1'b0, a);
    check(outs() == 3'b001, tag, 32'(outs()), 32'd1);
    check(flash_off == off, tag, 32'(flash_off), 32'(off));
  endtask

  task automatic expect_mem(input string tag, input bit wr, input logic [31:0] a);
    access(wr, a);
    check(outs() == 3'b010, tag, 32'(outs()), 32'd2);
    check(mem_addr == a, tag, mem_addr, a);
    check(mem_write == wr, tag, 32'(mem_write), 32'(wr));
  endtask

  task automatic t_reset();
    check(cfg_rdata == 16'hFFCC, "R1 reset value", 32'(cfg_rdata), 32'hFFCC);
    check(outs() == 3'b000, "R1 outputs idle", 32'(outs()), 32'd0);
    check(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_top_window();
    expect_flash("R3 start-up address", 32'hFFFF_FFF0, 23'h7F_FFF0);
    expect_flash("R3 window base", 32'hFFF8_0000, 23'h78_0000);
  endtask

  task automatic t_bit14();
    expect_flash("R4 bit14 set", 32'hFFF0_1234, 23'h70_1234);
    cfg_write(16'hBFCC);
    check(cfg_rdata == 16'hBFCC, "R4 readback", 32'(cfg_rdata), 32'hBFCC);
    expect_mem("R4 bit14 clear", 1'b0, 32'hFFF0_1234);
    cfg_write(16'hFFCC);
  endtask

  task automatic t_lock();
    cfg_write(16'h0000);
    check(cfg_rdata == 16'h8000, "R2 locked bit", 32'(cfg_rdata), 32'h8000);
    expect_flash("R2 top still flash", 32'hFFFF_0000, 23'h7F_0000);
    cfg_write(16'hFFCC);
  endtask

  task automatic t_low_windows();
    // FFCC: bits 2,3,6,7 set; bits 0,1,4,5 clear
    expect_flash("R5 bit2 window", 32'hFF90_0010, 23'h10_0010);
    expect_flash("R5 bit7 window", 32'hFFB8_0000, 23'h38_0000);
    expect_mem("R5 bit0 clear", 1'b0, 32'hFF80_0000);
    expect_mem("R5 bit5 clear", 1'b0, 32'hFFAF_FFFF);
  endtask

  task automatic t_memory();
    expect_mem("R6 low read", 1'b0, 32'h0010_0000);
    expect_mem("R6 write", 1'b1, 32'h1234_5678);
    expect_mem("R6 below alias", 1'b0, 32'h000E_FFFF);
  endtask

  task automatic t_blocked();
    access(1'b1, 32'hFFFF_FFF0);
    check(outs() == 3'b100, "R7 write blocked", 32'(outs()), 32'd4);
    @(negedge clk);
    check(outs() == 3'b000, "R7 one cycle", 32'(outs()), 32'd0);
    access(1'b1, 32'h000F_0000);
    check(outs() == 3'b100, "R7 alias write blocked", 32'(outs()), 32'd4);
  endtask

  task automatic t_alias();
    expect_flash("R8 alias top", 32'h000F_FFF0, 23'h7F_FFF0);
    expect_flash("R8 alias base", 32'h000F_0000, 23'h7F_0000);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hFFFF_FFFF;
    @(negedge clk);
    check(outs() == 3'b001, "R9 first of pair", 32'(outs()), 32'd1);
    req_addr = 32'h0000_1000;
    @(negedge clk);
    req_valid = 1'b0;
    check(outs() == 3'b010, "R9 second of pair", 32'(outs()), 32'd2);
    @(negedge clk);
    check(outs() == 3'b000, "R9 idle", 32'(outs()), 32'd0);
  endtask

  task automatic t_same_cycle_cfg();
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 16'hBFCC;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hFFF0_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    check(outs() == 3'b001, "R10 old value used", 32'(outs()), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(outs() == 3'b010, "R10 new value used", 32'(outs()), 32'd2);
    cfg_write(16'hFFCC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_top_window();
    t_bit14();
    t_lock();
    t_low_windows();
    t_memory();
    t_blocked();
    t_alias();
    t_back_to_back();
    t_same_cycle_cfg();
    check(req_ready == 1'b1, "R11 ready at end", 32'(req_ready), 32'd1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule